// File: doc/BRIEF.md
# Indexed and Paired Load/Store Address Generator

This block sits between instruction decode and the data-memory port of a 64-bit core. It accepts one decoded load or store at a time and works out where it goes in memory. There are three addressing forms:

- **Indexed:** a base plus a scaled index register.
- **Base-update:** a base plus a signed, scaled 5-bit immediate. The immediate is applied before or after the access, and the updated base is written back.
- **Paired:** two consecutive same-size transfers at a scaled offset from the base.

The block issues one memory beat, or two for a paired form, on a valid/ready request port. Load data returns with the accepted beat and is extended to 64 bits. The block then drives two register write ports, one for loaded data and one for the updated base.

Register combinations that the forms forbid are detected when the operation is accepted. Such an operation raises a one-cycle illegal flag and has no other effect. Doubleword accesses are refused outside 64-bit mode.

Top module: `idx_pair_agu`

## Requirements
- R1: With `op_kind`=0 (indexed) and `op_idx_zext`=0, the address is `op_base + (op_index << op_scale)` using the full 64-bit index.
- R2: With `op_kind`=0 and `op_idx_zext`=1, bits 31:0 of the index are zero-extended before the shift.
- R3: With `op_kind`=1 (base-update), the increment is the sign-extended `op_imm5` shifted left by `op_scale`. With `op_pre`=0 the access goes to the old base; with `op_pre`=1 it goes to base plus increment.
- R4: A base-update operation, load or store, writes base plus increment to register `op_rbase` through the base write port. The write comes one cycle after its beat is accepted.
- R5: A base-update load (`op_store`=0) whose `op_rbase` equals `op_rda` is illegal.
- R6: With `op_kind`=2 (paired), the first address is `op_base + (op_pair_off << 4)` for doublewords (`op_size`=3) and `op_base + (op_pair_off << 3)` for words (`op_size`=2). The first beat goes to that address. The second beat goes to the first address plus 8 or 4, and it carries `op_wdata_b` or loads into `op_rdb`.
- R7: A paired operation is illegal when `op_rbase` equals `op_rda` or `op_rbase` equals `op_rdb`, or when `op_rda` equals `op_rdb`.
- R8: Load data is extended by `op_size` (0 byte, 1 half, 2 word, 3 double). `op_signed`=1 sign-extends and `op_signed`=0 zero-extends. The extended value is written to the data register one cycle after the beat is accepted.
- R9: The following are illegal: `op_size`=3 while `mode_64`=0; a paired operation with `op_size` below 2; and `op_kind`=3.
- R10: An illegal operation raises `op_illegal` for one cycle and produces no memory beat, no register write and no `op_done`.
- R11: `op_ready` is low from acceptance until the last beat is accepted. `op_done` pulses once, one cycle after the final beat is accepted.
- R12: While `mem_valid` is high and `mem_ready` is low, the request is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Block idle; the offered operation is accepted |
| op_kind | input | 2 | 0 indexed, 1 base-update, 2 paired, 3 reserved |
| op_store | input | 1 | 1 store, 0 load |
| op_pre | input | 1 | Base-update: apply increment before the access |
| op_idx_zext | input | 1 | Indexed: zero-extend bits 31:0 of the index |
| op_size | input | 2 | Access size as a power of two in bytes |
| op_signed | input | 1 | Sign-extend loaded data |
| op_scale | input | 2 | Shift for the index or the immediate |
| op_imm5 | input | 5 | Signed increment |
| op_pair_off | input | 2 | Paired offset field |
| op_rbase | input | 5 | Base register number |
| op_rda | input | 5 | First data register number |
| op_rdb | input | 5 | Second data register number (paired) |
| op_base | input | 64 | Base register value |
| op_index | input | 64 | Index register value |
| op_wdata_a | input | 64 | Store data, first beat |
| op_wdata_b | input | 64 | Store data, second beat |
| mode_64 | input | 1 | 64-bit mode; doubleword forms allowed |
| mem_valid | output | 1 | Memory beat requested |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 64 | Beat address |
| mem_size | output | 2 | Beat size |
| mem_write | output | 1 | Beat is a store |
| mem_wdata | output | 64 | Store data |
| mem_rdata | input | 64 | Load data, valid with the accepted beat |
| rf_dwe | output | 1 | Data register write enable |
| rf_dwaddr | output | 5 | Data register number |
| rf_dwdata | output | 64 | Extended load data |
| rf_bwe | output | 1 | Base register write enable |
| rf_bwaddr | output | 5 | Base register number |
| rf_bwdata | output | 64 | Updated base |
| op_done | output | 1 | Operation finished |
| op_illegal | output | 1 | Operation refused |

## Verification
The first memory beat is requested in the cycle after the operation is accepted. The illegal flag also appears in that cycle. The data write, the base write and the done pulse each appear one cycle after the handshake edge of the beat that caused them.

The bench drives every input on the falling clock edge and samples every output there. Memory acceptance is throttled by a fixed stall pattern, so the checks are tied to handshakes rather than to fixed cycle counts. Each expected beat, write and flag is logged by kind and compared once the operation has gone quiet.

// File: rtl/idx_pair_agu.sv
module idx_pair_agu #(
  parameter int XLEN = 64,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [1:0]      op_kind,
  input  logic            op_store,
  input  logic            op_pre,
  input  logic            op_idx_zext,
  input  logic [1:0]      op_size,
  input  logic            op_signed,
  input  logic [1:0]      op_scale,
  input  logic [4:0]      op_imm5,
  input  logic [1:0]      op_pair_off,
  input  logic [RW-1:0]   op_rbase,
  input  logic [RW-1:0]   op_rda,
  input  logic [RW-1:0]   op_rdb,
  input  logic [XLEN-1:0] op_base,
  input  logic [XLEN-1:0] op_index,
  input  logic [XLEN-1:0] op_wdata_a,
  input  logic [XLEN-1:0] op_wdata_b,
  input  logic            mode_64,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [XLEN-1:0] mem_addr,
  output logic [1:0]      mem_size,
  output logic            mem_write,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            rf_dwe,
  output logic [RW-1:0]   rf_dwaddr,
  output logic [XLEN-1:0] rf_dwdata,
  output logic            rf_bwe,
  output logic [RW-1:0]   rf_bwaddr,
  output logic [XLEN-1:0] rf_bwdata,
  output logic            op_done,
  output logic            op_illegal
);

  localparam logic [1:0] K_IDX = 2'd0, K_UPD = 2'd1, K_PAIR = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_BEAT0, S_BEAT1} state_t;
  state_t st;

  logic [XLEN-1:0] idx_eff, incr, pair_offs, addr0, next_base, ld_ext, beat_bytes;
  logic            bad;

  logic [XLEN-1:0] r_addr, r_nbase, r_wa, r_wb;
  logic [RW-1:0]   r_rda, r_rdb, r_rbase;
  logic [1:0]      r_kind, r_size;
  logic            r_store, r_signed;

  assign idx_eff   = op_idx_zext ? {{(XLEN-32){1'b0}}, op_index[31:0]} : op_index;
  assign incr      = {{(XLEN-5){op_imm5[4]}}, op_imm5} << op_scale;
  assign pair_offs = {{(XLEN-2){1'b0}}, op_pair_off} << (op_size[0] ? 4 : 3);
  assign next_base = op_base + incr;

  always_comb begin
    case (op_kind)
      K_IDX:   addr0 = op_base + (idx_eff << op_scale);
      K_UPD:   addr0 = op_pre ? next_base : op_base;
      default: addr0 = op_base + pair_offs;
    endcase
  end

  assign bad = (op_kind == 2'd3)
             | (op_size == 2'd3 && !mode_64)
             | (op_kind == K_UPD && !op_store && op_rbase == op_rda)
             | (op_kind == K_PAIR && (op_size < 2'd2 || op_rbase == op_rda ||
                                      op_rbase == op_rdb || op_rda == op_rdb));

  always_comb begin
    case (r_size)
      2'd0:    ld_ext = {{(XLEN-8){r_signed & mem_rdata[7]}}, mem_rdata[7:0]};
      2'd1:    ld_ext = {{(XLEN-16){r_signed & mem_rdata[15]}}, mem_rdata[15:0]};
      2'd2:    ld_ext = {{(XLEN-32){r_signed & mem_rdata[31]}}, mem_rdata[31:0]};
      default: ld_ext = mem_rdata;
    endcase
  end

  assign beat_bytes = XLEN'(1) << r_size;
  assign op_ready   = (st == S_IDLE);
  assign mem_valid  = (st != S_IDLE);
  assign mem_addr   = r_addr;
  assign mem_size   = r_size;
  assign mem_write  = r_store;
  assign mem_wdata  = (st == S_BEAT1) ? r_wb : r_wa;
  assign rf_bwaddr  = r_rbase;
  assign rf_bwdata  = r_nbase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      r_addr <= '0; r_nbase <= '0; r_wa <= '0; r_wb <= '0;
      r_rda <= '0; r_rdb <= '0; r_rbase <= '0;
      r_kind <= '0; r_size <= '0; r_store <= 1'b0; r_signed <= 1'b0;
      rf_dwe <= 1'b0; rf_dwaddr <= '0; rf_dwdata <= '0;
      rf_bwe <= 1'b0; op_done <= 1'b0; op_illegal <= 1'b0;
    end else begin
      rf_dwe <= 1'b0; rf_bwe <= 1'b0; op_done <= 1'b0; op_illegal <= 1'b0;
      case (st)
        S_IDLE: if (op_valid) begin
          if (bad) op_illegal <= 1'b1;
          else begin
            st <= S_BEAT0;
            r_addr <= addr0; r_nbase <= next_base;
            r_wa <= op_wdata_a; r_wb <= op_wdata_b;
            r_rda <= op_rda; r_rdb <= op_rdb; r_rbase <= op_rbase;
            r_kind <= op_kind; r_size <= op_size;
            r_store <= op_store; r_signed <= op_signed;
          end
        end
        S_BEAT0: if (mem_ready) begin
          if (!r_store) begin
            rf_dwe <= 1'b1; rf_dwaddr <= r_rda; rf_dwdata <= ld_ext;
          end
          if (r_kind == K_UPD) rf_bwe <= 1'b1;
          if (r_kind == K_PAIR) begin
            st <= S_BEAT1;
            r_addr <= r_addr + beat_bytes;
          end else begin
            st <= S_IDLE;
            op_done <= 1'b1;
          end
        end
        default: if (mem_ready) begin
          if (!r_store) begin
            rf_dwe <= 1'b1; rf_dwaddr <= r_rdb; rf_dwdata <= ld_ext;
          end
          st <= S_IDLE;
          op_done <= 1'b1;
        end
      endcase
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata));

  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_illegal |-> !mem_valid && !rf_dwe && !rf_bwe && !op_done);

  // R11
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !op_ready);

  // R11
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> op_ready && $past(mem_valid && mem_ready));

  // R4
  base_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_bwe |-> $past(mem_valid && mem_ready) && !mem_valid);

  // R6
  pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BEAT0 && mem_ready && r_kind == K_PAIR) |=>
      mem_valid && mem_addr == $past(mem_addr) + (XLEN'(1) << mem_size));

endmodule

// File: tb/idx_pair_agu_tb.sv
module idx_pair_agu_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [1:0] kind; logic st, pre, zx; logic [1:0] sz; logic sg; logic [1:0] sc;
    logic [4:0] imm; logic [1:0] po; logic [4:0] rb, ra, r2; logic m64, ill;
    logic [63:0] base, index, a0, nb;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0,1'b0,1'b0,1'b0,2'd3,1'b0,2'd2,5'h00,2'd0,5'd1,5'd5,5'd0,1'b1,1'b0,64'h1000,64'h10,64'h1040,64'h0},
    '{2'd0,1'b0,1'b0,1'b1,2'd2,1'b1,2'd1,5'h00,2'd0,5'd1,5'd6,5'd0,1'b1,1'b0,64'h1000,64'hFFFF_FFFF_0000_0008,64'h1010,64'h0},
    '{2'd0,1'b0,1'b0,1'b0,2'd0,1'b1,2'd0,5'h00,2'd0,5'd1,5'd7,5'd0,1'b1,1'b0,64'h2000,64'hFFFF_FFFF_FFFF_FFFC,64'h1FFC,64'h0},
    '{2'd1,1'b0,1'b0,1'b0,2'd1,1'b0,2'd3,5'h1F,2'd0,5'd2,5'd3,5'd0,1'b1,1'b0,64'h3000,64'h0,64'h3000,64'h2FF8},
    '{2'd1,1'b1,1'b1,1'b0,2'd2,1'b0,2'd2,5'h04,2'd0,5'd4,5'd6,5'd0,1'b1,1'b0,64'h4000,64'h0,64'h4010,64'h4010},
    '{2'd1,1'b0,1'b1,1'b0,2'd2,1'b0,2'd2,5'h04,2'd0,5'd7,5'd7,5'd0,1'b1,1'b1,64'h4000,64'h0,64'h0,64'h0},
    '{2'd1,1'b1,1'b0,1'b0,2'd0,1'b0,2'd0,5'h01,2'd0,5'd8,5'd8,5'd0,1'b1,1'b0,64'h5000,64'h0,64'h5000,64'h5001},
    '{2'd2,1'b0,1'b0,1'b0,2'd3,1'b0,2'd0,5'h00,2'd2,5'd1,5'd2,5'd3,1'b1,1'b0,64'h6000,64'h0,64'h6020,64'h0},
    '{2'd2,1'b0,1'b0,1'b0,2'd2,1'b1,2'd0,5'h00,2'd3,5'd4,5'd5,5'd6,1'b1,1'b0,64'h7000,64'h0,64'h7018,64'h0},
    '{2'd2,1'b1,1'b0,1'b0,2'd2,1'b0,2'd0,5'h00,2'd1,5'd9,5'd10,5'd11,1'b1,1'b0,64'h8000,64'h0,64'h8008,64'h0},
    '{2'd2,1'b0,1'b0,1'b0,2'd2,1'b0,2'd0,5'h00,2'd0,5'd1,5'd2,5'd2,1'b1,1'b1,64'h8000,64'h0,64'h0,64'h0},
    '{2'd2,1'b0,1'b0,1'b0,2'd3,1'b0,2'd0,5'h00,2'd0,5'd3,5'd4,5'd3,1'b1,1'b1,64'h8000,64'h0,64'h0,64'h0},
    '{2'd0,1'b0,1'b0,1'b0,2'd3,1'b0,2'd0,5'h00,2'd0,5'd1,5'd2,5'd0,1'b0,1'b1,64'h1000,64'h0,64'h0,64'h0},
    '{2'd2,1'b0,1'b0,1'b0,2'd2,1'b0,2'd0,5'h00,2'd0,5'd12,5'd13,5'd14,1'b1,1'b0,64'h9000,64'h0,64'h9000,64'h0},
    '{2'd2,1'b0,1'b0,1'b0,2'd1,1'b0,2'd0,5'h00,2'd0,5'd1,5'd2,5'd3,1'b1,1'b1,64'h9000,64'h0,64'h0,64'h0}
  };

  localparam logic [63:0] RPAT = 64'h8123_4567_89AB_CDEF;
  localparam logic [63:0] WA   = 64'h1111_2222_3333_4444;
  localparam logic [63:0] WB   = 64'h5555_6666_7777_8888;

  logic op_valid, op_ready, op_store, op_pre, op_idx_zext, op_signed, mode_64;
  logic [1:0] op_kind, op_size, op_scale, op_pair_off;
  logic [4:0] op_imm5, op_rbase, op_rda, op_rdb;
  logic [63:0] op_base, op_index, op_wdata_a, op_wdata_b;
  logic mem_valid, mem_ready, mem_write;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0] mem_size;
  logic rf_dwe, rf_bwe, op_done, op_illegal;
  logic [4:0] rf_dwaddr, rf_bwaddr;
  logic [63:0] rf_dwdata, rf_bwdata;

  assign mem_rdata = RPAT + mem_addr;

  idx_pair_agu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_store(op_store), .op_pre(op_pre), .op_idx_zext(op_idx_zext),
    .op_size(op_size), .op_signed(op_signed), .op_scale(op_scale), .op_imm5(op_imm5),
    .op_pair_off(op_pair_off), .op_rbase(op_rbase), .op_rda(op_rda), .op_rdb(op_rdb),
    .op_base(op_base), .op_index(op_index), .op_wdata_a(op_wdata_a), .op_wdata_b(op_wdata_b),
    .mode_64(mode_64), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_write(mem_write), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_dwe(rf_dwe), .rf_dwaddr(rf_dwaddr), .rf_dwdata(rf_dwdata),
    .rf_bwe(rf_bwe), .rf_bwaddr(rf_bwaddr), .rf_bwdata(rf_bwdata),
    .op_done(op_done), .op_illegal(op_illegal));

  int nchk = 0, nfail = 0, cyc = 0;
  int nbeat, nrf, nbw, ndone, nill;
  logic [63:0] b_addr [4], b_wdata [4], rf_data [4], bw_data;
  logic [1:0]  b_size [4];
  logic        b_wr [4];
  logic [4:0]  rf_addr [4], bw_addr;
  logic        hold_pend;
  logic [63:0] hold_addr;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ext(input logic [63:0] d, input logic [1:0] sz, input logic sg);
    case (sz)
      2'd0: return sg ? {{56{d[7]}}, d[7:0]} : {56'b0, d[7:0]};
      2'd1: return sg ? {{48{d[15]}}, d[15:0]} : {48'b0, d[15:0]};
      2'd2: return sg ? {{32{d[31]}}, d[31:0]} : {32'b0, d[31:0]};
      default: return d;
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    mem_ready = (cyc % 3) != 0;
    if (rst_n) begin
      if (hold_pend && mem_valid) chk(mem_addr == hold_addr, "R12 hold", mem_addr, hold_addr);
      hold_pend = mem_valid && !mem_ready;
      hold_addr = mem_addr;
      if (mem_valid && mem_ready && nbeat < 4) begin
        b_addr[nbeat] = mem_addr; b_wdata[nbeat] = mem_wdata;
        b_size[nbeat] = mem_size; b_wr[nbeat] = mem_write; nbeat++;
      end
      if (rf_dwe && nrf < 4) begin rf_addr[nrf] = rf_dwaddr; rf_data[nrf] = rf_dwdata; nrf++; end
      if (rf_bwe) begin bw_addr = rf_bwaddr; bw_data = rf_bwdata; nbw++; end
      if (op_done) ndone++;
      if (op_illegal) nill++;
    end
    if (cyc > 20000) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic run(input int i);
    vec_t v = VECS[i];
    string t;
    int eb;
    logic [63:0] a;
    nbeat = 0; nrf = 0; nbw = 0; ndone = 0; nill = 0; hold_pend = 1'b0;
    op_kind = v.kind; op_store = v.st; op_pre = v.pre; op_idx_zext = v.zx;
    op_size = v.sz; op_signed = v.sg; op_scale = v.sc; op_imm5 = v.imm;
    op_pair_off = v.po; op_rbase = v.rb; op_rda = v.ra; op_rdb = v.r2;
    op_base = v.base; op_index = v.index; op_wdata_a = WA; op_wdata_b = WB;
    mode_64 = v.m64; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    t = v.ill ? "R5/R7/R9/R10" : (v.kind == 2'd0 ? "R1/R2" : (v.kind == 2'd1 ? "R3/R4" : "R6"));
    chk(op_ready == v.ill, "R11 ready", {63'b0, op_ready}, {63'b0, v.ill});
    repeat (24) @(negedge clk);
    eb = v.ill ? 0 : (v.kind == 2'd2 ? 2 : 1);
    chk(nbeat == eb, {t, " beats"}, 64'(nbeat), 64'(eb));
    chk(nill == int'(v.ill), "R10 illegal flag", 64'(nill), {63'b0, v.ill});
    chk(ndone == (v.ill ? 0 : 1), "R11 done", 64'(ndone), v.ill ? 64'd0 : 64'd1);
    for (int k = 0; k < eb && k < nbeat; k++) begin
      a = v.a0 + (k == 0 ? 64'd0 : (v.sz == 2'd3 ? 64'd8 : 64'd4));
      chk(b_addr[k] == a, {t, " addr"}, b_addr[k], a);
      chk(b_wr[k] == v.st && b_size[k] == v.sz, {t, " kind"}, {61'b0, b_wr[k], b_size[k]}, {61'b0, v.st, v.sz});
      if (v.st) chk(b_wdata[k] == (k == 0 ? WA : WB), {t, " wdata"}, b_wdata[k], k == 0 ? WA : WB);
    end
    if (!v.st && !v.ill) begin
      chk(nrf == eb, "R8 write count", 64'(nrf), 64'(eb));
      for (int k = 0; k < eb && k < nrf; k++) begin
        a = v.a0 + (k == 0 ? 64'd0 : (v.sz == 2'd3 ? 64'd8 : 64'd4));
        chk(rf_addr[k] == (k == 0 ? v.ra : v.r2), "R8 dest reg", 64'(rf_addr[k]), 64'(k == 0 ? v.ra : v.r2));
        chk(rf_data[k] == ext(RPAT + a, v.sz, v.sg), "R8 load data", rf_data[k], ext(RPAT + a, v.sz, v.sg));
      end
    end else begin
      chk(nrf == 0, "R10 no data write", 64'(nrf), 64'd0);
    end
    if (v.kind == 2'd1 && !v.ill) begin
      chk(nbw == 1 && bw_addr == v.rb, "R4 base reg", 64'(bw_addr), 64'(v.rb));
      chk(bw_data == v.nb, "R4 new base", bw_data, v.nb);
    end else begin
      chk(nbw == 0, "R4/R10 no base write", 64'(nbw), 64'd0);
    end
  endtask

  initial begin
    op_valid = 1'b0; op_kind = '0; op_store = 1'b0; op_pre = 1'b0; op_idx_zext = 1'b0;
    op_size = '0; op_signed = 1'b0; op_scale = '0; op_imm5 = '0; op_pair_off = '0;
    op_rbase = '0; op_rda = '0; op_rdb = '0; op_base = '0; op_index = '0;
    op_wdata_a = '0; op_wdata_b = '0; mode_64 = 1'b1; mem_ready = 1'b0;
    nbeat = 0; nrf = 0; nbw = 0; ndone = 0; nill = 0; hold_pend = 1'b0;
    repeat (3) @(negedge clk);
    chk(op_ready == 1'b1 && mem_valid == 1'b0, "R11 reset idle", {62'b0, op_ready, mem_valid}, 64'd2);
    chk(!rf_dwe && !rf_bwe && !op_done && !op_illegal, "R10 reset quiet",
        {60'b0, rf_dwe, rf_bwe, op_done, op_illegal}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run(i);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule